// File: doc/BRIEF.md
# Submission Queue Doorbell Tracker

This block follows one circular command submission ring from the device side. The host never sends a count of new commands. It only overwrites an absolute tail index through a doorbell write. The tracker keeps its own copy of that tail and works out how many slots each write adds by taking the wrap-aware distance from the previous tail. It keeps the consumer (head) index. While any slot is pending, it presents a fetch request for the slot at the head.

A downstream fetch engine reads the entry and pulses `fetch_done_i`. That pulse moves the head by one slot, so entries are handed out strictly in ring order. The head index is exported so that the completion path can copy it into each completion record. The host uses it to learn which slots it may reuse.

Doorbell values that are not a legal index, or that would overrun unconsumed slots, are refused. A refused write leaves the tail untouched and reports an error code. The ring size is a runtime input between 2 and the `MAX_DEPTH` parameter. A ring of size N holds at most N-1 pending entries.

Top module: `sq_doorbell_tracker`

## Requirements
- R1: After reset, head and tail are 0, `empty_o` is 1, `full_o`, `fetch_req_o` and `db_ack_o` are 0, `db_err_o` is 0 and `db_cnt_o` is 0.
- R2: An accepted doorbell write replaces the tail with `db_val_i` on the clock edge that samples it. In the following cycle `db_ack_o` is 1 for one cycle and `db_cnt_o` holds (new tail - old tail) mod size. `db_cnt_o` keeps that value until the next accepted write. Without a write, the tail does not change.
- R3: A doorbell value greater than or equal to `qsize_i` is refused. The tail is unchanged, `db_ack_o` stays 0, and `db_err_o` reads 2'd1 for one cycle in the following cycle.
- R4: A doorbell whose new-entry count exceeds the free slots, (size - 1 - occupancy), is refused. The tail is unchanged, `db_ack_o` stays 0, and `db_err_o` reads 2'd2 for one cycle in the following cycle. Code 2'd0 means no error.
- R5: `empty_o` is 1 exactly when head equals tail. In that case `fetch_req_o` is 0.
- R6: `full_o` is 1 exactly when (tail + 1) mod size equals head. `occupancy_o` never reaches `qsize_i`.
- R7: While head differs from tail, `fetch_req_o` is 1 and `fetch_slot_o` equals the head. Each `fetch_done_i` pulse in that state advances the head by one, wrapping from size-1 to 0.
- R8: `fetch_done_i` asserted while the ring is empty leaves the head unchanged.
- R9: `occupancy_o` equals (tail - head) mod size at all times.
- R10: A doorbell write equal to the current tail is accepted with a count of 0 and changes nothing else.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| qsize_i | input | CNT_W | Ring size, 2..MAX_DEPTH, held stable between resets |
| db_wr_i | input | 1 | Doorbell write strobe |
| db_val_i | input | PTR_W | New absolute tail index |
| db_ack_o | output | 1 | Previous-cycle doorbell accepted |
| db_err_o | output | 2 | Previous-cycle doorbell refused: 1 = out of range, 2 = overrun |
| db_cnt_o | output | PTR_W | Entries added by the last accepted doorbell |
| fetch_req_o | output | 1 | A slot is waiting to be fetched |
| fetch_slot_o | output | PTR_W | Index of the slot to fetch |
| fetch_done_i | input | 1 | Fetch of the requested slot finished |
| head_o | output | PTR_W | Consumer index, for completion records |
| tail_o | output | PTR_W | Producer index last accepted |
| occupancy_o | output | CNT_W | Pending entries |
| empty_o | output | 1 | Ring empty |
| full_o | output | 1 | Ring holds size-1 entries |

## Verification
The bench drives doorbells that wrap past slot 0. A design that subtracts without adding the size back would report a huge count, or would refuse them as overruns. It fills the ring to size-1 and then writes a tail equal to the head. A tracker that treated "equal" as zero new entries would silently drop a whole ring of commands, where it should flag an overrun. Fetch-done pulses arrive on an empty ring and in the same cycle as doorbell writes; a head that moved anyway would hand out stale slots. The bench also runs the smallest ring, size 2, and the largest one, where every index is legal, and then a long pseudo-random mix checked against a behavioural model on every clock.

// File: rtl/sq_trk_pkg.sv
package sq_trk_pkg;
  typedef enum logic [1:0] {
    DB_OK      = 2'd0,
    DB_RANGE   = 2'd1,
    DB_OVERRUN = 2'd2
  } db_verdict_e;
endpackage

// File: rtl/sq_mod_sub.sv
module sq_mod_sub #(
  parameter int PTR_W = 6,
  parameter int CNT_W = 7
) (
  input  logic [PTR_W-1:0] a_i,
  input  logic [PTR_W-1:0] b_i,
  input  logic [CNT_W-1:0] size_i,
  output logic [PTR_W-1:0] diff_o
);
  logic [CNT_W:0] res;
  always_comb begin
    if (a_i >= b_i) res = {{(CNT_W+1-PTR_W){1'b0}}, a_i} - {{(CNT_W+1-PTR_W){1'b0}}, b_i};
    else            res = {1'b0, size_i} + {{(CNT_W+1-PTR_W){1'b0}}, a_i}
                          - {{(CNT_W+1-PTR_W){1'b0}}, b_i};
  end
  assign diff_o = res[PTR_W-1:0];
endmodule

// File: rtl/sq_head_ctr.sv
module sq_head_ctr #(
  parameter int PTR_W = 6,
  parameter int CNT_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] size_i,
  input  logic             adv_i,
  output logic [PTR_W-1:0] head_o
);
  logic [PTR_W-1:0] head_q, head_inc;
  logic             at_last;

  assign at_last  = ({{(CNT_W-PTR_W){1'b0}}, head_q} == size_i - CNT_W'(1));
  assign head_inc = at_last ? '0 : head_q + PTR_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    head_q <= '0;
    else if (adv_i) head_q <= head_inc;
  end

  assign head_o = head_q;
endmodule

// File: rtl/sq_db_check.sv
module sq_db_check
  import sq_trk_pkg::*;
#(
  parameter int PTR_W = 6,
  parameter int CNT_W = 7
) (
  input  logic [CNT_W-1:0] size_i,
  input  logic [PTR_W-1:0] val_i,
  input  logic [PTR_W-1:0] new_cnt_i,
  input  logic [CNT_W-1:0] occ_i,
  output db_verdict_e      verdict_o
);
  logic [CNT_W-1:0] free_slots;
  logic             range_bad, overrun;

  assign range_bad  = {{(CNT_W-PTR_W){1'b0}}, val_i} >= size_i;
  assign free_slots = size_i - CNT_W'(1) - occ_i;
  assign overrun    = {{(CNT_W-PTR_W){1'b0}}, new_cnt_i} > free_slots;

  always_comb begin
    if (range_bad)    verdict_o = DB_RANGE;
    else if (overrun) verdict_o = DB_OVERRUN;
    else              verdict_o = DB_OK;
  end
endmodule

// File: rtl/sq_doorbell_tracker.sv
module sq_doorbell_tracker
  import sq_trk_pkg::*;
#(
  parameter int MAX_DEPTH = 64,
  localparam int PTR_W = $clog2(MAX_DEPTH),
  localparam int CNT_W = $clog2(MAX_DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] qsize_i,
  input  logic             db_wr_i,
  input  logic [PTR_W-1:0] db_val_i,
  output logic             db_ack_o,
  output logic [1:0]       db_err_o,
  output logic [PTR_W-1:0] db_cnt_o,
  output logic             fetch_req_o,
  output logic [PTR_W-1:0] fetch_slot_o,
  input  logic             fetch_done_i,
  output logic [PTR_W-1:0] head_o,
  output logic [PTR_W-1:0] tail_o,
  output logic [CNT_W-1:0] occupancy_o,
  output logic             empty_o,
  output logic             full_o
);
  localparam int N_SUB = 2;  // 0: occupancy, 1: doorbell delta

  logic [PTR_W-1:0] tail_q, head, cnt_q;
  logic             ack_q;
  db_verdict_e      err_q, verdict;
  logic [PTR_W-1:0] sub_a [N_SUB];
  logic [PTR_W-1:0] sub_b [N_SUB];
  logic [PTR_W-1:0] sub_d [N_SUB];
  logic [CNT_W-1:0] occ;
  logic [PTR_W-1:0] tail_inc;
  logic             empty, accept;

  assign sub_a[0] = tail_q;
  assign sub_b[0] = head;
  assign sub_a[1] = db_val_i;
  assign sub_b[1] = tail_q;

  for (genvar g = 0; g < N_SUB; g++) begin : g_sub
    sq_mod_sub #(.PTR_W(PTR_W), .CNT_W(CNT_W)) u_sub (
      .a_i   (sub_a[g]),
      .b_i   (sub_b[g]),
      .size_i(qsize_i),
      .diff_o(sub_d[g])
    );
  end

  assign occ   = {{(CNT_W-PTR_W){1'b0}}, sub_d[0]};
  assign empty = (head == tail_q);

  sq_db_check #(.PTR_W(PTR_W), .CNT_W(CNT_W)) u_chk_db (
    .size_i   (qsize_i),
    .val_i    (db_val_i),
    .new_cnt_i(sub_d[1]),
    .occ_i    (occ),
    .verdict_o(verdict)
  );

  assign accept = db_wr_i && (verdict == DB_OK);

  sq_head_ctr #(.PTR_W(PTR_W), .CNT_W(CNT_W)) u_head (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .size_i(qsize_i),
    .adv_i (fetch_done_i && !empty),
    .head_o(head)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tail_q <= '0;
      cnt_q  <= '0;
      ack_q  <= 1'b0;
      err_q  <= DB_OK;
    end else begin
      ack_q <= accept;
      err_q <= db_wr_i ? verdict : DB_OK;
      if (accept) begin
        tail_q <= db_val_i;
        cnt_q  <= sub_d[1];
      end
    end
  end

  // full: one slot kept open so full and empty stay distinct
  assign tail_inc = ({{(CNT_W-PTR_W){1'b0}}, tail_q} == qsize_i - CNT_W'(1)) ? '0 : tail_q + PTR_W'(1);

  assign db_ack_o     = ack_q;
  assign db_err_o     = err_q;
  assign db_cnt_o     = cnt_q;
  assign fetch_req_o  = !empty;
  assign fetch_slot_o = head;
  assign head_o       = head;
  assign tail_o       = tail_q;
  assign occupancy_o  = occ;
  assign empty_o      = empty;
  assign full_o       = (tail_inc == head);
endmodule

// File: rtl/sq_tracker_chk.sv
module sq_tracker_chk #(
  parameter int PTR_W = 6,
  parameter int CNT_W = 7
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CNT_W-1:0] qsize_i,
  input logic             db_wr_i,
  input logic [PTR_W-1:0] db_val_i,
  input logic             db_ack_o,
  input logic [1:0]       db_err_o,
  input logic             fetch_req_o,
  input logic             fetch_done_i,
  input logic [PTR_W-1:0] head_o,
  input logic [PTR_W-1:0] tail_o,
  input logic [CNT_W-1:0] occupancy_o,
  input logic             empty_o,
  input logic             full_o
);
  logic [PTR_W-1:0] head_next_exp;
  assign head_next_exp = ({{(CNT_W-PTR_W){1'b0}}, head_o} + CNT_W'(1) == qsize_i)
                         ? '0 : head_o + PTR_W'(1);

  assert_head_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_req_o && fetch_done_i |=> head_o == $past(head_next_exp));

  assert_head_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fetch_req_o && fetch_done_i) |=> $stable(head_o));

  assert_range_reject_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    db_wr_i && ({{(CNT_W-PTR_W){1'b0}}, db_val_i} >= qsize_i) |=> db_err_o == 2'd1 && $stable(tail_o));

  assert_tail_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    db_ack_o |-> tail_o == $past(db_val_i));

  assert_tail_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !db_wr_i |=> $stable(tail_o));

  assert_overrun_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    db_err_o == 2'd2 |-> $stable(tail_o) && !db_ack_o);

  assert_occ_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occupancy_o < qsize_i);

  assert_flags_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> !full_o && !fetch_req_o);
endmodule

bind sq_doorbell_tracker sq_tracker_chk #(.PTR_W(PTR_W), .CNT_W(CNT_W)) u_tracker_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .qsize_i     (qsize_i),
  .db_wr_i     (db_wr_i),
  .db_val_i    (db_val_i),
  .db_ack_o    (db_ack_o),
  .db_err_o    (db_err_o),
  .fetch_req_o (fetch_req_o),
  .fetch_done_i(fetch_done_i),
  .head_o      (head_o),
  .tail_o      (tail_o),
  .occupancy_o (occupancy_o),
  .empty_o     (empty_o),
  .full_o      (full_o)
);

// File: tb/sim_sq_doorbell_tracker.sv
`timescale 1ns/1ps
module sim_sq_doorbell_tracker;
  localparam int MAXD  = 64;
  localparam int PTR_W = $clog2(MAXD);
  localparam int CNT_W = $clog2(MAXD + 1);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [CNT_W-1:0] qsize = CNT_W'(8);
  logic             db_wr = 1'b0;
  logic [PTR_W-1:0] db_val = '0;
  logic             fetch_done = 1'b0;
  logic             db_ack, fetch_req, empty, full;
  logic [1:0]       db_err;
  logic [PTR_W-1:0] db_cnt, fetch_slot, head, tail;
  logic [CNT_W-1:0] occ;

  int n_tests = 0;
  int n_fail  = 0;

  // behavioural model state
  int m_size, m_head, m_tail, m_cnt, m_err, m_ack;

  always #2 clk = ~clk;  // 250 MHz

  sq_doorbell_tracker #(.MAX_DEPTH(MAXD)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .qsize_i(qsize),
    .db_wr_i(db_wr), .db_val_i(db_val),
    .db_ack_o(db_ack), .db_err_o(db_err), .db_cnt_o(db_cnt),
    .fetch_req_o(fetch_req), .fetch_slot_o(fetch_slot), .fetch_done_i(fetch_done),
    .head_o(head), .tail_o(tail), .occupancy_o(occ),
    .empty_o(empty), .full_o(full)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int occ_m();
    return (m_tail - m_head + m_size) % m_size;
  endfunction

  task automatic compare_all();
    int o;
    o = occ_m();
    chk("R7", "head", int'(head), m_head);
    chk("R2", "tail", int'(tail), m_tail);
    chk("R9", "occupancy", int'(occ), o);
    chk("R5", "empty", int'(empty), int'(o == 0));
    chk("R6", "full", int'(full), int'(o == m_size - 1));
    chk("R7", "fetch_req", int'(fetch_req), int'(o != 0));
    if (o != 0) chk("R7", "fetch_slot", int'(fetch_slot), m_head);
    chk("R2", "ack", int'(db_ack), m_ack);
    chk("R2", "count", int'(db_cnt), m_cnt);
    chk((m_err == 2) ? "R4" : "R3", "err", int'(db_err), m_err);
  endtask

  // one clock: drive at negedge, model at posedge, compare at next negedge
  task automatic cyc(input bit wr, input int val, input bit done);
    int o, c;
    db_wr = wr; db_val = PTR_W'(val); fetch_done = done;
    @(posedge clk);
    o = occ_m();
    m_ack = 0; m_err = 0;
    if (wr) begin
      if (val >= m_size) m_err = 1;
      else begin
        c = (val - m_tail + m_size) % m_size;
        if (c > m_size - 1 - o) m_err = 2;
        else begin m_tail = val; m_cnt = c; m_ack = 1; end
      end
    end
    if (done && o != 0) m_head = (m_head + 1) % m_size;
    @(negedge clk);
    db_wr = 1'b0; fetch_done = 1'b0;
    compare_all();
  endtask

  task automatic do_reset(input int sz);
    rst_n = 1'b0; qsize = CNT_W'(sz);
    db_wr = 1'b0; fetch_done = 1'b0;
    m_size = sz; m_head = 0; m_tail = 0; m_cnt = 0; m_err = 0; m_ack = 0;
    repeat (2) @(negedge clk);
    compare_all();  // R1 reset state
    rst_n = 1'b1;
    @(negedge clk);
    compare_all();
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : stim
    int unsigned seed;
    do_reset(8);
    // R1 explicit
    chk("R1", "reset empty", int'(empty), 1);
    chk("R1", "reset err", int'(db_err), 0);

    // R2: write announcing 3
    cyc(1, 3, 0);
    chk("R2", "count of 3", int'(db_cnt), 3);
    // R7: fetch in order while a write lands
    cyc(0, 0, 1);
    cyc(1, 6, 1);
    chk("R2", "second count", int'(db_cnt), 3);
    cyc(0, 0, 1);
    // R10: same tail again
    cyc(1, 6, 0);
    chk("R10", "same tail count", int'(db_cnt), 0);
    // R3: out of range
    cyc(1, 9, 0);
    chk("R3", "range err", int'(db_err), 1);
    // R2 wrap: tail 6 -> 2 adds 4
    cyc(1, 2, 0);
    chk("R2", "wrap count", int'(db_cnt), 4);
    // R6: fill to size-1 (head 3, tail to 2 already: occ 7)
    chk("R6", "full at 7", int'(full), 1);
    // R4: tail == head would overrun
    cyc(1, 3, 0);
    chk("R4", "overrun err", int'(db_err), 2);
    cyc(1, 4, 0);
    chk("R4", "overrun past head", int'(db_err), 2);
    // drain, head wraps 7 -> 0
    for (int i = 0; i < 9; i++) cyc(0, 0, 1);
    // R8: done on empty ring
    chk("R8", "head idle", int'(head), 2);
    cyc(1, 2, 1);
    chk("R8", "head after idle done", int'(head), 2);

    // largest ring: all indices legal
    do_reset(MAXD);
    cyc(1, MAXD - 1, 0);
    chk("R6", "full max ring", int'(full), 1);
    cyc(1, 0, 1);
    chk("R4", "overrun max ring", int'(db_err), 2);
    cyc(0, 0, 1);
    cyc(1, 0, 0);
    chk("R2", "wrap to 0 max ring", int'(db_cnt), 1);

    // smallest ring
    do_reset(2);
    cyc(1, 1, 0);
    chk("R6", "full size 2", int'(full), 1);
    cyc(1, 0, 0);
    chk("R4", "overrun size 2", int'(db_err), 2);
    cyc(1, 2, 0);
    chk("R3", "range size 2", int'(db_err), 1);
    cyc(0, 0, 1);
    cyc(1, 0, 1);

    // pseudo-random mix on size 5
    do_reset(5);
    seed = 32'h1234_5678;
    for (int i = 0; i < 400; i++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      cyc(seed[20], int'(seed[26:24]), seed[17]);
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule